// File: doc/BRIEF.md
# Decimal Seconds Tally

This block keeps a four-place decimal tally of elapsed seconds for a stopwatch-style display. A prescaler runs on the single system clock and raises a strobe for one cycle at the end of every period of `TICK_DIV` clocks. On each strobe the tally goes up by one in decimal. Each place is a 4-bit BCD nibble that never holds a value above nine.

The lowest place steps on every strobe. Any higher place steps only when every place below it reads nine. A place that reads nine wraps to zero, so 9999 rolls over to 0000. The `run` input pauses the prescaler and the tally without clearing them. A synchronous reset clears both. The period is a parameter: hardware uses a value near 2^26 and a bench uses a handful of cycles.

Top module: `decimal_tick_counter`

## Requirements
- R1: `tally` packs the places as follows: bits [3:0] hold the units, [7:4] the tens, [11:8] the hundreds and [15:12] the thousands, each as a plain BCD nibble.
- R2: Outside reset, every nibble of `tally` holds a value from 0 to 9.
- R3: On a strobe, the units nibble becomes 0 if it was 9 and otherwise increases by 1.
- R4: On a strobe, a higher nibble changes only if every nibble below it was 9. It then wraps 9 to 0 or increases by 1. In all other cases it keeps its value.
- R5: While `run` is high, a strobe occurs after every `TICK_DIV` clock cycles, counted from the end of reset. `tally` changes on no other cycle.
- R6: A strobe while `tally` reads 9999 makes it read 0000.
- R7: A cycle with `rst` high clears `tally` and the prescaler to zero. The first strobe after reset then comes `TICK_DIV` running cycles later.
- R8: While `run` is low, `tally` and the prescaler hold their values. When `run` returns high, counting resumes from the partial period already done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every flop uses its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | High to count; low to pause prescaler and tally |
| tally | output | 16 | Four BCD places, units in the lowest nibble |

## Verification
On every cycle, the assertions check the following: each nibble stays decimal, the units step is correct, higher places hold unless the units read nine, 9999 rolls over to zero, a pause freezes all state, and reset clears it. Other behaviour can only be shown by the bench's directed scenarios. These cover the exact cycle on which a strobe lands after reset or after a pause. They also cover carries into the tens, hundreds and thousands, and a reset issued partway through a period.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic advance;
    logic clear;
  } dtcStrobe_t;

  localparam int unsigned NIBBLE_W = 4;
  localparam logic [NIBBLE_W-1:0] NIBBLE_MAX = 4'd9;
endpackage

// File: rtl/dtc_prescaler.sv
module dtc_prescaler
  import dtc_pkg::*;
#(
  parameter int unsigned TICK_DIV = 32'd67108864,
  localparam int unsigned PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  output dtcStrobe_t strobe
);
  localparam logic [PRE_W-1:0] LAST = PRE_W'(TICK_DIV - 1);

  logic [PRE_W-1:0] preCnt;
  logic             atLast;

  assign atLast = (preCnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      preCnt <= '0;
    end else if (run) begin
      if (atLast) preCnt <= '0;
      else        preCnt <= preCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.clear   = rst;
    strobe.advance = run && atLast && !rst;
  end
endmodule

// File: rtl/dtc_bcd_digit.sv
module dtc_bcd_digit
  import dtc_pkg::*;
(
  input  logic                clk,
  input  logic                clear,
  input  logic                step,
  output logic [NIBBLE_W-1:0] digit
);
  always_ff @(posedge clk) begin
    if (clear) begin
      digit <= '0;
    end else if (step) begin
      if (digit == NIBBLE_MAX) digit <= '0;
      else                     digit <= digit + 1'b1;
    end
  end
endmodule

// File: rtl/dtc_digit_chain.sv
module dtc_digit_chain
  import dtc_pkg::*;
#(
  parameter int unsigned DIGITS = 4,
  localparam int unsigned TALLY_W = DIGITS * NIBBLE_W
) (
  input  logic               clk,
  input  dtcStrobe_t         strobe,
  output logic [TALLY_W-1:0] tally
);
  logic [DIGITS-1:0] lowerAllNine;

  for (genvar i = 0; i < DIGITS; i++) begin : g_place
    if (i == 0) begin : g_lsd
      assign lowerAllNine[i] = 1'b1;
    end else begin : g_upper
      assign lowerAllNine[i] = lowerAllNine[i-1] &&
                               (tally[(i-1)*NIBBLE_W +: NIBBLE_W] == NIBBLE_MAX);
    end

    dtc_bcd_digit i_digit (
      .clk  (clk),
      .clear(strobe.clear),
      .step (strobe.advance && lowerAllNine[i]),
      .digit(tally[i*NIBBLE_W +: NIBBLE_W])
    );
  end
endmodule

// File: rtl/decimal_tick_counter.sv
module decimal_tick_counter
  import dtc_pkg::*;
#(
  parameter int unsigned TICK_DIV = 32'd67108864,
  parameter int unsigned DIGITS   = 4,
  localparam int unsigned TALLY_W = DIGITS * NIBBLE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  output logic [TALLY_W-1:0] tally
);
  dtcStrobe_t strobe;

  dtc_prescaler #(.TICK_DIV(TICK_DIV)) i_ctrl (
    .clk   (clk),
    .rst   (rst),
    .run   (run),
    .strobe(strobe)
  );

  dtc_digit_chain #(.DIGITS(DIGITS)) i_data (
    .clk   (clk),
    .strobe(strobe),
    .tally (tally)
  );
endmodule

// File: rtl/dtc_checker.sv
module dtc_checker #(
  parameter int unsigned TICK_DIV = 5,
  parameter int unsigned PRE_W    = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             run,
  input logic [15:0]      tally,
  input logic             tick,
  input logic [PRE_W-1:0] preCnt
);
  logic rstSeen;
  always_ff @(posedge clk) rstSeen <= rst;

  // R7: a reset cycle leaves everything at zero
  always @(posedge clk) begin
    if (rstSeen) begin
      a_r7_reset_clears: assert (tally == 16'h0000 && preCnt == '0)
        else $error("R7 reset did not clear state");
    end
  end

  a_r2_nibbles_decimal: assert property (@(posedge clk) disable iff (rst)
    (tally[3:0] <= 4'd9) && (tally[7:4] <= 4'd9) &&
    (tally[11:8] <= 4'd9) && (tally[15:12] <= 4'd9));

  a_r3_units_step: assert property (@(posedge clk) disable iff (rst)
    tick |=> tally[3:0] == (($past(tally[3:0]) == 4'd9) ? 4'd0 : $past(tally[3:0]) + 4'd1));

  a_r4_upper_hold: assert property (@(posedge clk) disable iff (rst)
    (tick && tally[3:0] != 4'd9) |=> $stable(tally[15:4]));

  a_r5_quiet_without_tick: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(tally));

  a_r5_tick_restarts: assert property (@(posedge clk) disable iff (rst)
    tick |=> preCnt == '0);

  a_r6_rollover: assert property (@(posedge clk) disable iff (rst)
    (tick && tally == 16'h9999) |=> tally == 16'h0000);

  a_r8_pause_freezes: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(tally) && $stable(preCnt));
endmodule

bind decimal_tick_counter dtc_checker #(
  .TICK_DIV(TICK_DIV),
  .PRE_W   ((TICK_DIV > 1) ? $clog2(TICK_DIV) : 1)
) i_chk (
  .clk   (clk),
  .rst   (rst),
  .run   (run),
  .tally (tally),
  .tick  (strobe.advance),
  .preCnt(i_ctrl.preCnt)
);

// File: tb/test_decimal_tick_counter.sv
`timescale 1ns/1ps
module test_decimal_tick_counter;
  localparam int unsigned DIV = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b1;
  logic [15:0] tally;
  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  decimal_tick_counter #(.TICK_DIV(DIV), .DIGITS(4)) i_decimal_tick_counter (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .tally(tally)
  );

  function automatic logic [15:0] toBcd(input int n);
    return {4'((n / 1000) % 10), 4'((n / 100) % 10), 4'((n / 10) % 10), 4'(n % 10)};
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    waitCycles(2);
    rst = 1'b0;
  endtask

  task automatic tReset();
    run = 1'b1;
    doReset();
    check("R7 reset clears tally", tally, 16'h0000);
    waitCycles(DIV - 1);
    check("R5 no strobe before full period", tally, 16'h0000);
    waitCycles(1);
    check("R3 first strobe gives 0001", tally, 16'h0001);
  endtask

  task automatic tUnitsCarry();
    doReset();
    waitCycles(9 * DIV);
    check("R3 units reach nine", tally, 16'h0009);
    waitCycles(DIV);
    check("R4 carry into tens", tally, 16'h0010);
    waitCycles(DIV);
    check("R4 tens hold when units not nine", tally, 16'h0011);
  endtask

  task automatic tUpperPlaces();
    doReset();
    waitCycles(99 * DIV);
    check("R4 before hundreds carry", tally, toBcd(99));
    waitCycles(DIV);
    check("R4 carry into hundreds", tally, 16'h0100);
    waitCycles(23 * DIV);
    check("R1 nibble placement 123", tally, 16'h0123);
    waitCycles((999 - 123) * DIV);
    check("R4 before thousands carry", tally, 16'h0999);
    waitCycles(DIV);
    check("R4 carry into thousands", tally, 16'h1000);
  endtask

  task automatic tRollover();
    doReset();
    waitCycles(9999 * DIV);
    check("R6 full count 9999", tally, 16'h9999);
    waitCycles(DIV);
    check("R6 rollover to 0000", tally, 16'h0000);
    waitCycles(DIV);
    check("R6 counting resumes after rollover", tally, 16'h0001);
  endtask

  task automatic tPause();
    doReset();
    waitCycles(DIV + 2);
    run = 1'b0;
    waitCycles(30);
    check("R8 paused tally holds", tally, 16'h0001);
    run = 1'b1;
    waitCycles(DIV - 3);
    check("R8 prescaler kept partial period", tally, 16'h0001);
    waitCycles(1);
    check("R8 strobe after remaining cycles", tally, 16'h0002);
  endtask

  task automatic tMidReset();
    doReset();
    waitCycles(7 * DIV + 3);
    check("R5 seven strobes", tally, 16'h0007);
    rst = 1'b1;
    waitCycles(1);
    rst = 1'b0;
    check("R7 mid-run reset clears tally", tally, 16'h0000);
    waitCycles(DIV - 1);
    check("R7 prescaler cleared by reset", tally, 16'h0000);
    waitCycles(1);
    check("R7 first strobe after reset", tally, 16'h0001);
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected<=150000 cycles", cyc);
      finishRun();
    end
  end

  initial begin
    waitCycles(3);
    tReset();
    tUnitsCarry();
    tUpperPlaces();
    tRollover();
    tPause();
    tMidReset();
    finishRun();
  end
endmodule